// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the coherence controller of one processor's cache on a shared memory bus. Several identical controllers and one memory sit on that bus. It keeps a small direct-mapped array of one-word lines, and each line is Invalid, Shared or Private. Local CPU reads and writes arrive over a ready/valid handshake. The controller serves them from the array when it can. Otherwise it wins the bus and runs a read or a write transaction.

The controller also watches the transactions that other caches put on the bus. A remote write drops the local copy of the word. A remote read of a word this cache holds Private makes the controller assert an inhibit line so that memory stays silent. The controller then puts the word on the bus itself and keeps only a Shared copy.

The first local write to a word goes through to memory and leaves the line Private. Later writes to that line stay inside the cache. A Private line that must make room for another address is first written back to memory.

Top module: `wonce_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `m_valid` and `s_inhibit` are low. The first access to any address after a reset therefore needs a bus read.
- R2: A read that hits completes in the cycle it is presented. It returns the stored word on `cpu_rdata` with `cpu_ready` high, and `bus_req` stays low.
- R3: A read miss issues one bus read (`m_op` = 0) of the requested address. It installs the word returned with `m_rvalid` as Shared and then completes the request with that word.
- R4: A write that hits a Shared line issues one bus write (`m_op` = 1) carrying the address and the new word. The line then becomes Private.
- R5: A write that hits a Private line updates only the cache, with no bus request. A later read returns the new word.
- R6: A write miss writes the word through to memory in one bus write. It installs the word in the cache and marks the line Private.
- R7: A snooped write (`s_valid` with `s_op` = 1) to an address held Shared or Private makes the local line Invalid. The next local read of that address goes to the bus.
- R8: A snooped read (`s_op` = 0) of an address held Private raises `s_inhibit` in that same cycle, with the stored word on `s_data`. The line then becomes Shared, so a second snooped read sees no inhibit and the next local write is written through.
- R9: A snooped read of an address that is absent or only Shared leaves `s_inhibit` low.
- R10: A transaction (`m_valid`) starts only in a cycle with `bus_gnt` high and `bus_busy` low. Until then `bus_req` is held high.
- R11: A snoop takes priority over the CPU. In a cycle with `s_valid` high, `cpu_ready` is low.
- R12: A miss whose line index holds Private data for another address first writes that old word back to the old address, and only then runs the read or write-through for the new one. The line index is the low `IDX_W` address bits and the tag is the rest.
- R13: A miss whose line index holds only Shared data for another address does no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | CPU request present, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Word to write |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Arbiter grant |
| bus_busy | input | 1 | Bus control line asserted by another requester |
| m_valid | output | 1 | Transaction issued this cycle |
| m_op | output | 1 | 0 = read, 1 = write |
| m_addr | output | ADDR_W | Transaction address |
| m_wdata | output | DATA_W | Write word |
| m_rvalid | input | 1 | Read data present on the bus |
| m_rdata | input | DATA_W | Read data from memory or from an owning cache |
| s_valid | input | 1 | Another cache's transaction is on the bus |
| s_op | input | 1 | 0 = read, 1 = write |
| s_addr | input | ADDR_W | Snooped address |
| s_inhibit | output | 1 | Memory must not answer; this cache supplies the word |
| s_data | output | DATA_W | Word supplied while s_inhibit is high |

## Verification
The hardest state to reach from the ports is a Private line owned by this cache that another cache then reads. This is also the only path that drives the inhibit output. The stimulus gets there with a local write miss and follows it with two snooped reads of the same word, so the demotion to Shared shows in the second reply. A later local write to that word then proves the line was demoted, because it produces a fresh write-through. Eviction ordering is reached by making a line Private and then reading an address that aliases to the same index. The bench watches the order of the logged bus operations, and a separate run holds the bus busy to show the request waiting.

// File: rtl/wonce_pkg.sv
package wonce_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_PRV = 2'd2
   } line_st_e;

   typedef enum logic [2:0] {
      C_IDLE  = 3'd0,
      C_WB    = 3'd1,
      C_FILL  = 3'd2,
      C_FWAIT = 3'd3,
      C_WT    = 3'd4
   } ctl_st_e;

   localparam logic OP_RD = 1'b0;
   localparam logic OP_WR = 1'b1;

endpackage

// File: rtl/wonce_lines.sv
// Direct-mapped line store: state, tag and one data word per line.
// Two combinational read ports (CPU side, snoop side) and two write ports.
// The snoop port only rewrites state and wins over the controller port.
module wonce_lines
   import wonce_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  c_idx,
   output line_st_e          c_st,
   output logic [TAG_W-1:0]  c_tag,
   output logic [DATA_W-1:0] c_data,
   input  logic [IDX_W-1:0]  s_idx,
   output line_st_e          s_st,
   output logic [TAG_W-1:0]  s_tag,
   output logic [DATA_W-1:0] s_data,
   input  logic              w_en,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [TAG_W-1:0]  w_tag,
   input  line_st_e          w_st,
   input  logic              w_den,
   input  logic [DATA_W-1:0] w_data,
   input  logic              v_en,
   input  logic [IDX_W-1:0]  v_idx,
   input  line_st_e          v_st
);

   localparam int LINES = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("wonce_lines: IDX_W out of range");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wonce_lines: TAG_W must be positive");
   end

   line_st_e          st_a  [LINES];
   logic [TAG_W-1:0]  tag_a [LINES];
   logic [DATA_W-1:0] dat_a [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;
      logic              sel_w, sel_v;

      assign sel_w = w_en && (w_idx == IDX_W'(g));
      assign sel_v = v_en && (v_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LN_INV;
            tag_q <= '0;
            dat_q <= '0;
         end else begin
            if (sel_v)
               st_q <= v_st;
            else if (sel_w)
               st_q <= w_st;
            if (sel_w)
               tag_q <= w_tag;
            if (sel_w && w_den)
               dat_q <= w_data;
         end
      end

      assign st_a[g]  = st_q;
      assign tag_a[g] = tag_q;
      assign dat_a[g] = dat_q;
   end

   assign c_st   = st_a[c_idx];
   assign c_tag  = tag_a[c_idx];
   assign c_data = dat_a[c_idx];
   assign s_st   = st_a[s_idx];
   assign s_tag  = tag_a[s_idx];
   assign s_data = dat_a[s_idx];

endmodule

// File: rtl/wonce_snoop.sv
// Snoop decision: invalidation on remote writes, ownership hand-off on
// remote reads of Private lines.
module wonce_snoop
   import wonce_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              s_valid,
   input  logic              s_op,
   input  logic [TAG_W-1:0]  s_tag,
   input  line_st_e          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              s_inhibit,
   output logic [DATA_W-1:0] s_data,
   output logic              v_en,
   output line_st_e          v_st
);

   logic hit;

   assign hit = s_valid && (ln_st != LN_INV) && (ln_tag == s_tag);

   always_comb begin
      s_inhibit = 1'b0;
      v_en      = 1'b0;
      v_st      = ln_st;
      if (hit) begin
         if (s_op == OP_WR) begin
            v_en = 1'b1;
            v_st = LN_INV;
         end else if (ln_st == LN_PRV) begin
            s_inhibit = 1'b1;
            v_en      = 1'b1;
            v_st      = LN_SHR;
         end
      end
   end

   assign s_data = s_inhibit ? ln_data : '0;

endmodule

// File: rtl/wonce_ctrl.sv
// CPU-side controller: hit handling, write-back of Private victims,
// fills, write-throughs and the bus request handshake.
module wonce_ctrl
   import wonce_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              s_valid,
   input  line_st_e          ln_st,
   input  logic [ADDR_W-IDX_W-1:0] ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              w_en,
   output logic [ADDR_W-IDX_W-1:0] w_tag,
   output line_st_e          w_st,
   output logic              w_den,
   output logic [DATA_W-1:0] w_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              bus_busy,
   output logic              m_valid,
   output logic              m_op,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic              m_rvalid,
   input  logic [DATA_W-1:0] m_rdata
);

   localparam int TAG_W = ADDR_W - IDX_W;

   ctl_st_e st_q, st_d, ret_q, ret_d;

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic             hit, go;

   assign idx = cpu_addr[IDX_W-1:0];
   assign tag = cpu_addr[ADDR_W-1:IDX_W];
   assign hit = (ln_st != LN_INV) && (ln_tag == tag);
   assign go  = bus_gnt && !bus_busy;
   assign cpu_rdata = ln_data;

   always_comb begin
      st_d      = st_q;
      ret_d     = ret_q;
      cpu_ready = 1'b0;
      bus_req   = 1'b0;
      m_valid   = 1'b0;
      m_op      = OP_RD;
      m_addr    = cpu_addr;
      m_wdata   = cpu_wdata;
      w_en      = 1'b0;
      w_tag     = tag;
      w_st      = ln_st;
      w_den     = 1'b0;
      w_data    = cpu_wdata;
      case (st_q)
         C_IDLE: begin
            if (cpu_valid && !s_valid) begin
               if (hit && !cpu_we) begin
                  cpu_ready = 1'b1;
               end else if (hit && ln_st == LN_PRV) begin
                  cpu_ready = 1'b1;
                  w_en      = 1'b1;
                  w_st      = LN_PRV;
                  w_den     = 1'b1;
               end else if (hit) begin
                  st_d = C_WT;
               end else if (ln_st == LN_PRV) begin
                  st_d  = C_WB;
                  ret_d = cpu_we ? C_WT : C_FILL;
               end else begin
                  st_d = cpu_we ? C_WT : C_FILL;
               end
            end
         end
         C_WB: begin
            if (ln_st != LN_PRV) begin
               st_d = ret_q;
            end else begin
               bus_req = 1'b1;
               if (go) begin
                  m_valid = 1'b1;
                  m_op    = OP_WR;
                  m_addr  = {ln_tag, idx};
                  m_wdata = ln_data;
                  w_en    = 1'b1;
                  w_tag   = ln_tag;
                  w_st    = LN_INV;
                  st_d    = ret_q;
               end
            end
         end
         C_FILL: begin
            bus_req = 1'b1;
            if (go) begin
               m_valid = 1'b1;
               m_op    = OP_RD;
               st_d    = C_FWAIT;
            end
         end
         C_FWAIT: begin
            if (m_rvalid) begin
               w_en   = 1'b1;
               w_st   = LN_SHR;
               w_den  = 1'b1;
               w_data = m_rdata;
               st_d   = C_IDLE;
            end
         end
         C_WT: begin
            bus_req = 1'b1;
            if (go) begin
               m_valid = 1'b1;
               m_op    = OP_WR;
               w_en    = 1'b1;
               w_st    = LN_PRV;
               w_den   = 1'b1;
               st_d    = C_IDLE;
            end
         end
         default: st_d = C_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= C_IDLE;
         ret_q <= C_IDLE;
      end else begin
         st_q  <= st_d;
         ret_q <= ret_d;
      end
   end

   // R10: a transaction only goes out on a free, granted bus
   p_bus_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (bus_gnt && !bus_busy));

   // R10: a pending request is held until it is served
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !go && !s_valid) |=> bus_req);

   // R4/R6: a write-through leaves the addressed line Private
   p_wt_private_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == C_WT && go && !s_valid) |=> (ln_st == LN_PRV));

   // R3: returned fill data is installed Shared
   p_fill_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == C_FWAIT && m_rvalid && !s_valid) |=>
         (ln_st == LN_SHR && ln_data == $past(m_rdata)));

endmodule

// File: rtl/wonce_snoop_cache.sv
module wonce_snoop_cache
   import wonce_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              bus_busy,
   output logic              m_valid,
   output logic              m_op,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic              m_rvalid,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic              s_valid,
   input  logic              s_op,
   input  logic [ADDR_W-1:0] s_addr,
   output logic              s_inhibit,
   output logic [DATA_W-1:0] s_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("wonce_snoop_cache: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wonce_snoop_cache: DATA_W must be positive");
   end

   line_st_e          c_st, s_st, w_st, v_st;
   logic [TAG_W-1:0]  c_tag, s_tag_q, w_tag;
   logic [DATA_W-1:0] c_data, s_dat_q, w_data;
   logic              w_en, w_den, v_en;

   wonce_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .c_idx  (cpu_addr[IDX_W-1:0]),
      .c_st   (c_st),
      .c_tag  (c_tag),
      .c_data (c_data),
      .s_idx  (s_addr[IDX_W-1:0]),
      .s_st   (s_st),
      .s_tag  (s_tag_q),
      .s_data (s_dat_q),
      .w_en   (w_en),
      .w_idx  (cpu_addr[IDX_W-1:0]),
      .w_tag  (w_tag),
      .w_st   (w_st),
      .w_den  (w_den),
      .w_data (w_data),
      .v_en   (v_en),
      .v_idx  (s_addr[IDX_W-1:0]),
      .v_st   (v_st)
   );

   wonce_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .s_valid   (s_valid),
      .s_op      (s_op),
      .s_tag     (s_addr[ADDR_W-1:IDX_W]),
      .ln_st     (s_st),
      .ln_tag    (s_tag_q),
      .ln_data   (s_dat_q),
      .s_inhibit (s_inhibit),
      .s_data    (s_data),
      .v_en      (v_en),
      .v_st      (v_st)
   );

   wonce_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_ready (cpu_ready),
      .cpu_rdata (cpu_rdata),
      .s_valid   (s_valid),
      .ln_st     (c_st),
      .ln_tag    (c_tag),
      .ln_data   (c_data),
      .w_en      (w_en),
      .w_tag     (w_tag),
      .w_st      (w_st),
      .w_den     (w_den),
      .w_data    (w_data),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .bus_busy  (bus_busy),
      .m_valid   (m_valid),
      .m_op      (m_op),
      .m_addr    (m_addr),
      .m_wdata   (m_wdata),
      .m_rvalid  (m_rvalid),
      .m_rdata   (m_rdata)
   );

   // R11: the CPU side is stalled whenever a snoop is present
   p_snoop_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |-> !cpu_ready);

   // R2/R5: a completing CPU access uses no bus
   p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready) |-> (!bus_req && !m_valid));

   // R8: after supplying data the same snooped word is no longer owned
   p_inhibit_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_inhibit && s_valid && !cpu_valid) |=>
         !(s_inhibit && s_addr == $past(s_addr)));

endmodule

// File: tb/sim_wonce_snoop_cache.sv
module sim_wonce_snoop_cache;

   localparam int AW = 8;
   localparam int DW = 16;

   typedef struct packed {
      logic        we;
      logic [7:0]  a;
      logic [15:0] wd;
      logic [15:0] ex;
      logic [3:0]  nrd;
      logic [3:0]  nwr;
   } vec_t;

   // memory holds a*3+7 at reset of the bench
   localparam vec_t VEC [10] = '{
      '{1'b0, 8'h10, 16'h0000, 16'h0037, 4'd1, 4'd0},
      '{1'b0, 8'h10, 16'h0000, 16'h0037, 4'd0, 4'd0},
      '{1'b1, 8'h10, 16'hAAAA, 16'h0000, 4'd0, 4'd1},
      '{1'b1, 8'h10, 16'hBBBB, 16'h0000, 4'd0, 4'd0},
      '{1'b0, 8'h10, 16'h0000, 16'hBBBB, 4'd0, 4'd0},
      '{1'b1, 8'h21, 16'h1234, 16'h0000, 4'd0, 4'd1},
      '{1'b0, 8'h21, 16'h0000, 16'h1234, 4'd0, 4'd0},
      '{1'b0, 8'h14, 16'h0000, 16'h0043, 4'd1, 4'd1},
      '{1'b0, 8'h10, 16'h0000, 16'hBBBB, 4'd1, 4'd0},
      '{1'b0, 8'h22, 16'h0000, 16'h006D, 4'd1, 4'd0}
   };
   localparam string VTAG [10] = '{"R3", "R2", "R4", "R5", "R5",
                                   "R6", "R6", "R12", "R13", "R3"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic bus_req;
   logic bus_gnt = 1'b1, bus_busy = 1'b0;
   logic m_valid, m_op;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic m_rvalid = 1'b0;
   logic [DW-1:0] m_rdata = '0;
   logic s_valid = 1'b0, s_op = 1'b0;
   logic [AW-1:0] s_addr = '0;
   logic s_inhibit;
   logic [DW-1:0] s_data;

   always #10 clk = ~clk;

   wonce_snoop_cache #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_busy(bus_busy),
      .m_valid(m_valid), .m_op(m_op), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rvalid(m_rvalid), .m_rdata(m_rdata),
      .s_valid(s_valid), .s_op(s_op), .s_addr(s_addr),
      .s_inhibit(s_inhibit), .s_data(s_data)
   );

   logic [DW-1:0] mem [256];
   logic          log_op   [64];
   logic [AW-1:0] log_addr [64];
   logic [DW-1:0] log_data [64];
   int nlog = 0, nrd = 0, nwr = 0;
   int errors = 0, checks = 0;
   int busy_cnt = 0, busy_viol = 0, req_in_busy = 0;
   logic pend = 1'b0;
   logic [AW-1:0] pend_a = '0;
   logic smp_ready, smp_inh;
   logic [DW-1:0] smp_rdata, smp_sdata;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one cycle: sample just after the negedge, act as memory, advance
   task automatic tick();
      #1;
      smp_ready = cpu_ready;
      smp_rdata = cpu_rdata;
      smp_inh   = s_inhibit;
      smp_sdata = s_data;
      if (bus_busy && bus_req) req_in_busy++;
      if (m_valid) begin
         if (bus_busy) busy_viol++;
         if (nlog < 64) begin
            log_op[nlog] = m_op; log_addr[nlog] = m_addr; log_data[nlog] = m_wdata;
            nlog++;
         end
         if (m_op) begin
            nwr++; mem[m_addr] = m_wdata;
         end else begin
            nrd++; pend = 1'b1; pend_a = m_addr;
         end
      end
      @(posedge clk);
      @(negedge clk);
      m_rvalid = pend;
      m_rdata  = pend ? mem[pend_a] : '0;
      pend     = 1'b0;
      if (busy_cnt > 0) busy_cnt--;
      bus_busy = (busy_cnt > 0);
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd);
      bit done = 0;
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      for (int k = 0; k < 40 && !done; k++) begin
         tick();
         if (smp_ready) done = 1;
      end
      cpu_valid = 1'b0;
      rd = smp_rdata;
      if (!done) check("R10", "cpu access never completed", 0, 1);
   endtask

   task automatic snoop(input logic op, input logic [AW-1:0] a,
                        output logic inh, output logic [DW-1:0] sd);
      s_valid = 1'b1; s_op = op; s_addr = a;
      tick();
      inh = smp_inh; sd = smp_sdata;
      s_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd, sd;
      logic inh;
      int r0, w0, l0;
      for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 7);

      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      #1;
      check("R1", "bus_req in reset", {31'b0, bus_req}, 0);
      check("R1", "m_valid in reset", {31'b0, m_valid}, 0);
      check("R1", "s_inhibit in reset", {31'b0, s_inhibit}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk
      for (int i = 0; i < 10; i++) begin
         r0 = nrd; w0 = nwr; l0 = nlog;
         cpu_op(VEC[i].we, VEC[i].a, VEC[i].wd, rd);
         if (!VEC[i].we) check(VTAG[i], "rdata", 32'(rd), 32'(VEC[i].ex));
         check(VTAG[i], "bus reads", nrd - r0, 32'(VEC[i].nrd));
         check(VTAG[i], "bus writes", nwr - w0, 32'(VEC[i].nwr));
         if (i == 2) check("R4", "memory after write-through", 32'(mem[8'h10]), 32'hAAAA);
         if (i == 3) check("R5", "memory untouched by local write", 32'(mem[8'h10]), 32'hAAAA);
         if (i == 5) check("R6", "memory after write miss", 32'(mem[8'h21]), 32'h1234);
         if (i == 7) begin
            check("R12", "first op is write-back", {23'b0, log_op[l0], log_addr[l0]}, {23'b0, 1'b1, 8'h10});
            check("R12", "write-back data", 32'(log_data[l0]), 32'hBBBB);
            check("R12", "second op is fill read", {23'b0, log_op[l0+1], log_addr[l0+1]}, {23'b0, 1'b0, 8'h14});
         end
      end

      // R8 / R6: remote read of the Private word 0x21
      snoop(1'b0, 8'h21, inh, sd);
      check("R8", "inhibit on Private hit", {31'b0, inh}, 1);
      check("R8", "supplied data", 32'(sd), 32'h1234);
      snoop(1'b0, 8'h21, inh, sd);
      check("R8", "no inhibit after demotion", {31'b0, inh}, 0);
      w0 = nwr;
      cpu_op(1'b1, 8'h21, 16'h5555, rd);
      check("R8", "write after demotion goes to bus", nwr - w0, 1);
      check("R4", "memory holds new word", 32'(mem[8'h21]), 32'h5555);

      // R7: remote write to a Private line
      snoop(1'b1, 8'h21, inh, sd);
      check("R7", "no inhibit on snooped write", {31'b0, inh}, 0);
      r0 = nrd;
      cpu_op(1'b0, 8'h21, '0, rd);
      check("R7", "read after remote write misses", nrd - r0, 1);
      check("R7", "refetched word", 32'(rd), 32'h5555);

      // R7: remote write to a Shared line
      snoop(1'b1, 8'h22, inh, sd);
      r0 = nrd;
      cpu_op(1'b0, 8'h22, '0, rd);
      check("R7", "Shared line invalidated", nrd - r0, 1);
      check("R7", "refetched Shared word", 32'(rd), 32'h006D);

      // R9: remote reads of absent and Shared lines
      snoop(1'b0, 8'h33, inh, sd);
      check("R9", "no inhibit on miss", {31'b0, inh}, 0);
      snoop(1'b0, 8'h22, inh, sd);
      check("R9", "no inhibit on Shared", {31'b0, inh}, 0);

      // R11: snoop and CPU hit in the same cycle
      cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h22;
      s_valid = 1'b1; s_op = 1'b0; s_addr = 8'h33;
      tick();
      check("R11", "cpu stalled by snoop", {31'b0, smp_ready}, 0);
      s_valid = 1'b0;
      tick();
      check("R11", "cpu served after snoop", {31'b0, smp_ready}, 1);
      check("R11", "cpu data after snoop", 32'(smp_rdata), 32'h006D);
      cpu_valid = 1'b0;

      // R10: bus busy delays the transaction
      busy_cnt = 4; bus_busy = 1'b1;
      busy_viol = 0; req_in_busy = 0;
      r0 = nrd;
      cpu_op(1'b0, 8'h30, '0, rd);
      check("R10", "transactions while busy", busy_viol, 0);
      check("R10", "request held while busy", {31'b0, req_in_busy >= 3}, 1);
      check("R10", "read done after busy", nrd - r0, 1);
      check("R10", "data after busy", 32'(rd), 32'h0097);

      // R1: reset drops all lines
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      check("R1", "bus_req in second reset", {31'b0, bus_req}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      r0 = nrd;
      cpu_op(1'b0, 8'h22, '0, rd);
      check("R1", "cached word lost by reset", nrd - r0, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule